// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the status register and the write-protection decisions of a small serial NOR flash. An SPI front end has already decoded each command into a one-cycle strobe: write enable, write disable, status write (with its data byte), page program, sector erase and bulk erase (with an address). The block decides whether each modifying command may proceed. It reports a one-cycle grant or reject pulse, the live status byte, and the current protection mode.

Protection has two layers. Two block-protect bits select a top-aligned group of 64 KiB sectors in a 256 KiB array, and that region refuses program and erase. A sticky write-disable bit, combined with a low level on the write-protect pin, locks the status register itself. This hardware lock can be entered in either order. It ends only when the pin goes high. The pin passes through a synchroniser first. A busy input from the program/erase engine blocks all commands and appears as the write-in-progress bit.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0 except bit0, no grant or reject is pulsed, and mode_o is 0.
- R2: Status layout: bit0 write-in-progress (follows busy_i directly), bit1 write-enable latch, bit2 and bit3 block-protect bits 0 and 1, bits 6:4 always 0, bit7 write-disable. The latch is set only by a write-enable strobe. It is cleared by a write-disable strobe and by every status write, program or erase, whether granted or refused.
- R3: A status write issued while the latch is clear is refused and changes no status bit.
- R4: With the write-disable bit at 0, a status write with the latch set is granted whatever the pin level. Data bits 7, 3 and 2 load the write-disable bit and block-protect bits 1 and 0.
- R5: With the write-disable bit at 1 and the synchronised pin high, a status write with the latch set is granted.
- R6: With the write-disable bit at 1 and the synchronised pin low (hardware mode), every status write is refused and bits 7, 3 and 2 stay frozen. The mode is reached either by writing the bit while the pin is low or by lowering the pin after the bit is set.
- R7: Hardware mode is left only by driving the pin high. A refused write never releases it.
- R8: A page program or sector erase to a protected sector is refused. An unprotected address with the latch set is granted. The sector is addr_i[17:16]. Block-protect 00 protects nothing, 01 protects sector 3, 10 protects sectors 2 and 3, and 11 protects all sectors.
- R9: Bulk erase is granted only when the latch is set and both block-protect bits are 0.
- R10: While busy_i is high every strobe is ignored: there is no pulse and no status change.
- R11: mode_o is 2 in hardware mode, 1 when the block-protect bits are non-zero outside hardware mode, and 0 otherwise.
- R12: grant_o and reject_o pulse in the cycle after the strobe and are never both high. A change on wp_n_i reaches mode_o after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Raw write-protect pin, low protects |
| busy_i | input | 1 | Program/erase engine busy |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status write strobe |
| sr_data_i | input | 8 | Status write data byte |
| prog_i | input | 1 | Page program strobe |
| serase_i | input | 1 | Sector erase strobe |
| berase_i | input | 1 | Bulk erase strobe |
| addr_i | input | ADDR_W | Command byte address |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Modifying command accepted |
| reject_o | output | 1 | Modifying command refused |
| mode_o | output | 2 | Protection mode |

## Verification
The assertions assume the front end raises at most one command strobe per cycle, holds each strobe for a single cycle, and keeps busy_i low around reset release. The bench drives every strobe for exactly one cycle at the falling edge and never overlaps two of them. It changes the pin only between commands and then waits at least three cycles, so that every expectation sees a settled synchronised level. Busy is raised only after reset and only around ignored commands.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_HARD = 2'd2
  } wp_mode_e;

  localparam int SR_WIP  = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP0  = 2;
  localparam int SR_BP1  = 3;
  localparam int SR_SRWD = 7;
endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/wp_region.sv
module wp_region #(
  parameter int ADDR_W   = 18,
  parameter int SECTOR_W = 2
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int SECTORS = 1 << SECTOR_W;

  logic [SECTOR_W-1:0] sector;
  int unsigned         guarded;

  assign sector = addr_i[ADDR_W-1 -: SECTOR_W];

  always_comb begin
    case (bp_i)
      2'd0:    guarded = 0;
      2'd1:    guarded = 1;
      2'd2:    guarded = 2;
      default: guarded = SECTORS;
    endcase
    prot_o = (guarded != 0) && (int'(sector) >= SECTORS - int'(guarded));
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SECTOR_W    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              prog_i,
  input  logic              serase_i,
  input  logic              berase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic [1:0]        mode_o
);
  logic       wp_safe;
  logic       addr_prot;
  logic       hw_lock;
  logic       any_cmd, st_en;
  logic       wel_q, wel_d;
  logic [1:0] bp_q, bp_d;
  logic       srwd_q, srwd_d;
  logic       grant_d, reject_d;
  wp_mode_e   mode;

  wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(wp_n_i), .pin_o(wp_safe)
  );

  wp_region #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_region (
    .bp_i(bp_q), .addr_i(addr_i), .prot_o(addr_prot)
  );

  assign hw_lock = srwd_q && !wp_safe;
  assign any_cmd = wren_i | wrdi_i | wrsr_i | prog_i | serase_i | berase_i;
  assign st_en   = any_cmd && !busy_i;

  // next-state decision
  always_comb begin
    wel_d    = wel_q;
    bp_d     = bp_q;
    srwd_d   = srwd_q;
    grant_d  = 1'b0;
    reject_d = 1'b0;
    if (!busy_i) begin
      if (wren_i) begin
        wel_d = 1'b1;
      end else if (wrdi_i) begin
        wel_d = 1'b0;
      end else if (wrsr_i) begin
        wel_d = 1'b0;
        if (wel_q && !hw_lock) begin
          grant_d = 1'b1;
          bp_d    = {sr_data_i[SR_BP1], sr_data_i[SR_BP0]};
          srwd_d  = sr_data_i[SR_SRWD];
        end else begin
          reject_d = 1'b1;
        end
      end else if (prog_i || serase_i) begin
        wel_d    = 1'b0;
        grant_d  = wel_q && !addr_prot;
        reject_d = !(wel_q && !addr_prot);
      end else if (berase_i) begin
        wel_d    = 1'b0;
        grant_d  = wel_q && (bp_q == 2'b00);
        reject_d = !(wel_q && (bp_q == 2'b00));
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      bp_q   <= 2'b00;
      srwd_q <= 1'b0;
    end else if (st_en) begin
      wel_q  <= wel_d;
      bp_q   <= bp_d;
      srwd_q <= srwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= grant_d;
      reject_o <= reject_d;
    end
  end

  always_comb begin
    if (hw_lock)            mode = MODE_HARD;
    else if (bp_q != 2'b00) mode = MODE_SOFT;
    else                    mode = MODE_OPEN;
  end

  assign mode_o   = mode;
  assign status_o = {srwd_q, 3'b000, bp_q, wel_q, busy_i};
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_s,
  input logic       busy_i,
  input logic       wren_i,
  input logic       wrsr_i,
  input logic       berase_i,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       reject_o,
  input logic [1:0] mode_o
);
  // R12
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && reject_o));

  // R2
  wel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(wren_i && !busy_i));

  // R3
  sr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !busy_i && !status_o[1]) |=> (reject_o && !grant_o));

  // R6
  hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !busy_i && status_o[7] && !wp_s) |=>
      (reject_o && status_o[7] && $stable(status_o[3:2])));

  // R7
  hw_exit_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 2'd2 && mode_o != 2'd2) |-> wp_s);

  // R9
  bulk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (berase_i && !busy_i && status_o[3:2] != 2'b00) |=> reject_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (!grant_o && !reject_o && status_o[7:1] == $past(status_o[7:1])));

  // R11
  hard_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (status_o[7] && !wp_s));
endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_s(wp_safe), .busy_i(busy_i),
  .wren_i(wren_i), .wrsr_i(wrsr_i), .berase_i(berase_i),
  .status_o(status_o), .grant_o(grant_o), .reject_o(reject_o),
  .mode_o(mode_o)
);

// File: tb/flash_wp_ctrl_bench.sv
module flash_wp_ctrl_bench;
  localparam int ADDR_W = 18;
  localparam int K_WREN = 0, K_WRDI = 1, K_WRSR = 2, K_PP = 3, K_SE = 4, K_BE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, busy = 1'b0;
  logic wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, prog = 1'b0, serase = 1'b0, berase = 1'b0;
  logic [7:0] sr_data = 8'h00;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] status;
  logic grant, reject;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit e_wel = 0, e_srwd = 0;
  int e_bp = 0;

  always #10 clk = ~clk;

  flash_wp_ctrl u_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .busy_i(busy),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .sr_data_i(sr_data),
    .prog_i(prog), .serase_i(serase), .berase_i(berase), .addr_i(addr),
    .status_o(status), .grant_o(grant), .reject_o(reject), .mode_o(mode)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit sector_prot(int bp, int sec);
    int n;
    n = (bp == 0) ? 0 : (bp == 3) ? 4 : (1 << (bp - 1));
    return (n != 0) && (sec >= 4 - n);
  endfunction

  function automatic int exp_status();
    return (int'(e_srwd) << 7) | (e_bp << 2) | (int'(e_wel) << 1) | int'(busy);
  endfunction

  function automatic int exp_mode();
    if (e_srwd && !wp_n) return 2;
    return (e_bp != 0) ? 1 : 0;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(bit v);
    wp_n = v;
    tick(3);
  endtask

  // one strobe; outputs checked at the following falling edge
  task automatic cmd(int kind, int data, int sec, string tag);
    bit ok = 0, modifying = 1;
    sr_data = data[7:0];
    addr = ADDR_W'(sec) << (ADDR_W - 2);
    case (kind)
      K_WREN: begin wren = 1; modifying = 0; end
      K_WRDI: begin wrdi = 1; modifying = 0; end
      K_WRSR: wrsr = 1;
      K_PP:   prog = 1;
      K_SE:   serase = 1;
      default: berase = 1;
    endcase
    case (kind)
      K_WREN: e_wel = 1;
      K_WRDI: e_wel = 0;
      K_WRSR: begin
        ok = e_wel && !(e_srwd && !wp_n);
        if (ok) begin e_srwd = data[7]; e_bp = (data >> 2) & 3; end
      end
      K_PP, K_SE: ok = e_wel && !sector_prot(e_bp, sec);
      default: ok = e_wel && (e_bp == 0);
    endcase
    if (modifying) e_wel = 0;
    tick(1);
    {wren, wrdi, wrsr, prog, serase, berase} = '0;
    check({tag, " grant"}, grant, modifying && ok);
    check({tag, " reject"}, reject, modifying && !ok);
    check({tag, " status"}, status, exp_status());
    check({tag, " mode"}, mode, exp_mode());
    tick(1);
  endtask

  task automatic force_sr(int bp, bit srwd);
    set_pin(1);
    cmd(K_WREN, 0, 0, "R2 setup");
    cmd(K_WRSR, (int'(srwd) << 7) | (bp << 2), 0, "R5 setup");
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    // R1
    check("R1 status", status, 0);
    check("R1 grant", grant, 0);
    check("R1 reject", reject, 0);
    check("R1 mode", mode, 0);

    // R3: status write without latch
    cmd(K_WRSR, 8'h8C, 0, "R3");
    // R2: latch set then cleared
    cmd(K_WREN, 0, 0, "R2 set");
    cmd(K_WRDI, 0, 0, "R2 clear");
    // R4: srwd=0 writes accepted with pin low; bits 6:4 ignored
    set_pin(0);
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 8'h7C, 0, "R4 pin low");
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 8'h00, 0, "R4 clear");

    // R8/R9 sweep over bp, srwd, pin, sector, command, latch
    for (int bp = 0; bp < 4; bp++)
      for (int sw = 0; sw < 2; sw++)
        for (int pin = 0; pin < 2; pin++) begin
          force_sr(bp, sw[0]);
          set_pin(pin[0]);
          for (int sec = 0; sec < 4; sec++)
            for (int k = K_PP; k <= K_BE; k++)
              for (int w = 0; w < 2; w++) begin
                if (w) cmd(K_WREN, 0, 0, "R2");
                cmd(k, 0, sec, (k == K_BE) ? "R9 sweep" : "R8 sweep");
              end
          // R5 or R6 depending on pin: attempt to clear everything
          cmd(K_WREN, 0, 0, "R2");
          cmd(K_WRSR, 8'h00, 0, (sw == 1 && pin == 0) ? "R6 frozen" : "R5 write");
        end

    // R6 order 2: set srwd while pin already low
    set_pin(1);
    force_sr(0, 0);
    set_pin(0);
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 8'h84, 0, "R6 enter via bit");
    check("R6 mode hard", mode, 2);
    // R7: refused write keeps lock
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 8'h00, 0, "R7 refused");
    // R12 sync latency on release
    wp_n = 1;
    tick(1);
    check("R12 one edge", mode, 2);
    tick(1);
    check("R12 two edges R7 exit", mode, 1);
    tick(1);
    // R6 order 1: lower pin after bit set
    wp_n = 0;
    tick(2);
    check("R6 enter via pin", mode, 2);
    tick(1);

    // R10 busy
    set_pin(1);
    busy = 1;
    tick(1);
    check("R10 wip", status[0], 1);
    wren = 1; tick(1); wren = 0;
    check("R10 wren ignored", status, 8'h85);
    check("R10 no pulse", grant | reject, 0);
    wrsr = 1; sr_data = 8'h00; tick(1); wrsr = 0;
    check("R10 wrsr ignored", status, 8'h85);
    check("R10 no reject", reject, 0);
    busy = 0;
    tick(1);
    check("R10 wip low", status[0], 0);
    cmd(K_WREN, 0, 0, "R2");
    cmd(K_WRSR, 8'h00, 0, "R5 final");
    check("R11 open", mode, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule